// File: doc/BRIEF.md
# Teletext PDC packet acquisition unit

This block sits behind a teletext data slicer and framer. Each incoming packet arrives as a stream of bytes, one per clock when `byte_vld` is high. `pkt_sof` marks the first byte, which has packet index 1. At that first byte the framer also states whether the packet is the magazine 8 / row 30 broadcast service packet (`row_sel`) and which format it carries (`fmt2_sel`).

From format-1 packets the unit keeps the date and time bytes exactly as they arrived. From format-2 packets it decodes the Hamming 8/4 protected label bytes and corrects single-bit errors. It then packs the recovered nibbles into a seven-byte transfer image.

A host interface reads either image through a small combinational read port. While it is reading, it holds `host_busy` so that a new packet cannot overwrite the transfer registers. `dav_n` tells the host that fresh format-2 label data is waiting. The next data entry window clears it.

Top module: `pdc_acq_unit`

## Requirements
- R1: Only a packet whose first byte arrives with `row_sel` high is acquired. Any other packet leaves both images and `dav_n` unchanged.
- R2: A format-2 codeword holds bits P1 D1 P2 D2 P3 D3 P4 D4 in `byte_data[0]` to `byte_data[7]`, with even parity on every check. Four checks are used: P1^D1^D3^D4, D1^P2^D2^D4, D1^D2^P3^D3, and the parity of all eight bits. A single-bit error is corrected. If any of packet bytes 13 to 25 has a two-bit error, the whole packet is dropped.
- R3: For format 1, packet bytes 15 to 21 go to image bytes 0 to 6 unchanged in content. Each byte is bit-reversed so that output bit 7 is `byte_data[0]` as received.
- R4: Each format-2 image byte is formed from two packet bytes: the first one's nibble goes in bits 7:4 and the second one's nibble in bits 3:0. Image byte 0 uses packet bytes 16 and 17, byte 1 uses 18 and 19, byte 2 uses 20 and 21, byte 3 uses 22 and 23, byte 4 uses 14 and 15, and byte 5 uses 24 and 25.
- R5: Every nibble is placed first-received-bit-high, so D1 lands in the upper bit of its nibble. Format-2 image byte 6 holds the nibble of packet byte 13 in bits 7:4 and 1111 in bits 3:0.
- R6: `dav_n` falls two clock edges after the edge that accepts packet byte 25 of a stored format-2 packet. A format-1 packet never drives it low.
- R7: A `dew_start` pulse sets `dav_n` high at the next clock edge, unless a format-2 store happens on that same edge.
- R8: If `host_busy` is high on the edge where a packet would be stored, the packet is discarded. Both images and `dav_n` keep their values.
- R9: `rd_data` shows byte `rd_idx` of the format-2 image when `rd_fmt2` is 1, and of the format-1 image when it is 0. It follows the read inputs combinationally. For `rd_idx` = 7 it returns 8'hFF.
- R10: After reset, every byte of both images reads 8'hFF and `dav_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_sof | input | 1 | First byte of a packet (index 1), valid with byte_vld |
| byte_vld | input | 1 | byte_data carries a packet byte |
| byte_data | input | 8 | Packet byte, bit 0 received first |
| row_sel | input | 1 | Packet is magazine 8 row 30 (sampled at pkt_sof) |
| fmt2_sel | input | 1 | 1 = format 2, 0 = format 1 (sampled at pkt_sof) |
| dew_start | input | 1 | Start of data entry window pulse |
| host_busy | input | 1 | Host access in progress, blocks stores |
| rd_fmt2 | input | 1 | Read-port image select |
| rd_idx | input | 3 | Read-port byte index |
| rd_data | output | 8 | Selected image byte |
| dav_n | output | 1 | Format-2 data available, active low |

## Verification
Each packet's result is due two edges after its last relevant byte is accepted. That is byte 25 for format 2 and byte 21 for format 1: one edge registers the commit and the next writes the image. The bench checks `dav_n` at the falling edge just before that second edge, where the old value must still show, and compares both images only after the whole packet and two drain cycles. `dew_start` is driven for one cycle and its effect is read at the following falling edge. Reads are combinational, so the bench changes `rd_idx`/`rd_fmt2` and samples one nanosecond later without waiting for any clock edge.

// File: rtl/pdc_acq_pkg.sv
package pdc_acq_pkg;
   typedef logic [7:0] byte_t;
   typedef logic [3:0] nib_t;

   localparam int F2_LO  = 13;                  // first protected label byte
   localparam int F2_HI  = 25;                  // last protected label byte
   localparam int NIB_N  = F2_HI - F2_LO + 1;   // nibbles staged per packet
   localparam int F1_LO  = 15;                  // first date/time byte
   localparam int OUT_N  = 7;                   // bytes in a transfer image
   localparam int F1_HI  = F1_LO + OUT_N - 1;
   localparam nib_t FILL = 4'hF;

   // staged nibble feeding the upper half of image byte k
   function automatic int hi_nib(input int k);
      case (k)
         0: return 3;
         1: return 5;
         2: return 7;
         3: return 9;
         4: return 1;
         5: return 11;
         default: return 0;
      endcase
   endfunction

   // staged nibble feeding the lower half; -1 selects the fill pattern
   function automatic int lo_nib(input int k);
      case (k)
         0: return 4;
         1: return 6;
         2: return 8;
         3: return 10;
         4: return 2;
         5: return 12;
         default: return -1;
      endcase
   endfunction

   function automatic nib_t flip4(input nib_t n);
      return {n[0], n[1], n[2], n[3]};
   endfunction

   function automatic byte_t flip8(input byte_t b);
      byte_t r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction
endpackage

// File: rtl/pdc_ham84_dec.sv
module pdc_ham84_dec
   import pdc_acq_pkg::*;
#(
   parameter bit CORRECT_EN = 1'b1
) (
   input  byte_t cw,
   output nib_t  nib,
   output logic  fatal
);
   logic       chk_a, chk_b, chk_c, chk_all;
   logic [2:0] syn;

   always_comb begin
      chk_a   = cw[0] ^ cw[1] ^ cw[5] ^ cw[7];
      chk_b   = cw[1] ^ cw[2] ^ cw[3] ^ cw[7];
      chk_c   = cw[1] ^ cw[3] ^ cw[4] ^ cw[5];
      chk_all = ^cw;
      syn     = {chk_c, chk_b, chk_a};
   end

   generate
      if (CORRECT_EN) begin : g_fix
         byte_t fixed_cw;
         always_comb begin
            fixed_cw = cw;
            fatal    = 1'b0;
            if (syn != 3'b000 && !chk_all) begin
               fatal = 1'b1;
            end else if (syn != 3'b000) begin
               case (syn)
                  3'b111: fixed_cw[1] = ~cw[1];
                  3'b110: fixed_cw[3] = ~cw[3];
                  3'b101: fixed_cw[5] = ~cw[5];
                  3'b011: fixed_cw[7] = ~cw[7];
                  default: fixed_cw = cw;   // a parity bit was hit
               endcase
            end
            nib = {fixed_cw[7], fixed_cw[5], fixed_cw[3], fixed_cw[1]};
         end
      end else begin : g_detect
         always_comb begin
            fatal = (syn != 3'b000) || chk_all;
            nib   = {cw[7], cw[5], cw[3], cw[1]};
         end
      end
   endgenerate
endmodule

// File: rtl/pdc_pkt_capture.sv
module pdc_pkt_capture
   import pdc_acq_pkg::*;
#(
   parameter int CNT_W      = 6,
   parameter bit CORRECT_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pkt_sof,
   input  logic                 byte_vld,
   input  byte_t                byte_data,
   input  logic                 row_sel,
   input  logic                 fmt2_sel,
   output logic                 commit,
   output logic                 commit_fmt2,
   output logic                 commit_bad,
   output logic [NIB_N*4-1:0]   nib_flat,
   output logic [OUT_N*8-1:0]   f1_flat
);
   localparam logic [CNT_W-1:0] IDX_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] IDX_F2E = CNT_W'(F2_HI);
   localparam logic [CNT_W-1:0] IDX_F1E = CNT_W'(F1_HI);

   logic [CNT_W-1:0] cnt_q, cur_idx, last_idx;
   logic             act_q, fmt2_q, bad_q, commit_q, cfmt2_q;
   logic             act_now, fmt_now, take, in_f2, is_last, bad_nx;
   nib_t             dec_nib;
   logic             dec_fatal;
   nib_t             nib_q [NIB_N];
   byte_t            f1_q  [OUT_N];

   pdc_ham84_dec #(.CORRECT_EN(CORRECT_EN)) u_dec (
      .cw    (byte_data),
      .nib   (dec_nib),
      .fatal (dec_fatal)
   );

   always_comb begin
      cur_idx  = pkt_sof ? IDX_ONE : cnt_q + IDX_ONE;
      act_now  = pkt_sof ? row_sel  : act_q;
      fmt_now  = pkt_sof ? fmt2_sel : fmt2_q;
      last_idx = fmt_now ? IDX_F2E : IDX_F1E;
      take     = byte_vld && act_now;
      is_last  = cur_idx == last_idx;
      in_f2    = (int'(cur_idx) >= F2_LO) && (int'(cur_idx) <= F2_HI);
      bad_nx   = (pkt_sof ? 1'b0 : bad_q) | (take && fmt_now && in_f2 && dec_fatal);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         act_q    <= 1'b0;
         fmt2_q   <= 1'b0;
         bad_q    <= 1'b0;
         commit_q <= 1'b0;
         cfmt2_q  <= 1'b0;
      end else begin
         commit_q <= take && is_last;
         if (byte_vld) begin
            cnt_q   <= cur_idx;
            act_q   <= act_now && !is_last;
            fmt2_q  <= fmt_now;
            bad_q   <= bad_nx;
            cfmt2_q <= fmt_now;
         end
      end
   end

   generate
      for (genvar i = 0; i < NIB_N; i++) begin : g_nib
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               nib_q[i] <= FILL;
            else if (take && fmt_now && cur_idx == CNT_W'(F2_LO + i))
               nib_q[i] <= dec_nib;
         end
         assign nib_flat[i*4 +: 4] = nib_q[i];
      end
      for (genvar j = 0; j < OUT_N; j++) begin : g_f1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               f1_q[j] <= 8'hFF;
            else if (take && !fmt_now && cur_idx == CNT_W'(F1_LO + j))
               f1_q[j] <= byte_data;
         end
         assign f1_flat[j*8 +: 8] = f1_q[j];
      end
   endgenerate

   assign commit      = commit_q;
   assign commit_fmt2 = cfmt2_q;
   assign commit_bad  = bad_q;

   // R1
   commit_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> $past(act_q));

   // R2
   fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !pkt_sof && act_q && fmt2_q && in_f2 && dec_fatal) |=> bad_q);
endmodule

// File: rtl/pdc_xfer_image.sv
module pdc_xfer_image
   import pdc_acq_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 commit,
   input  logic                 commit_fmt2,
   input  logic                 commit_bad,
   input  logic [NIB_N*4-1:0]   nib_flat,
   input  logic [OUT_N*8-1:0]   f1_flat,
   input  logic                 dew_start,
   input  logic                 host_busy,
   input  logic                 rd_fmt2,
   input  logic [2:0]           rd_idx,
   output byte_t                rd_data,
   output logic                 dav_n
);
   logic [OUT_N*8-1:0] img2_q, img1_q, img2_nx, img1_nx;
   logic               store2, store1, dav_q;

   generate
      for (genvar k = 0; k < OUT_N; k++) begin : g_pack
         localparam int HI = hi_nib(k);
         localparam int LO = lo_nib(k);
         if (LO < 0) begin : g_fill
            assign img2_nx[k*8 +: 8] = {flip4(nib_flat[HI*4 +: 4]), FILL};
         end else begin : g_pair
            assign img2_nx[k*8 +: 8] = {flip4(nib_flat[HI*4 +: 4]),
                                        flip4(nib_flat[LO*4 +: 4])};
         end
         assign img1_nx[k*8 +: 8] = flip8(f1_flat[k*8 +: 8]);
      end
   endgenerate

   always_comb begin
      store2 = commit && commit_fmt2 && !commit_bad && !host_busy;
      store1 = commit && !commit_fmt2 && !host_busy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         img2_q <= '1;
         img1_q <= '1;
         dav_q  <= 1'b1;
      end else begin
         if (store2) img2_q <= img2_nx;
         if (store1) img1_q <= img1_nx;
         if (store2)         dav_q <= 1'b0;
         else if (dew_start) dav_q <= 1'b1;
      end
   end

   always_comb begin
      rd_data = 8'hFF;
      for (int k = 0; k < OUT_N; k++) begin
         if (rd_idx == 3'(k))
            rd_data = rd_fmt2 ? img2_q[k*8 +: 8] : img1_q[k*8 +: 8];
      end
   end

   assign dav_n = dav_q;

   // R6
   dav_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dav_q) |-> $past(commit && commit_fmt2 && !host_busy));

   // R6
   fmt1_keeps_dav_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !commit_fmt2 && dav_q) |=> dav_q);

   // R7
   dew_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dew_start && !commit) |=> dav_q);

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && host_busy) |=> ($stable(img2_q) && $stable(img1_q) && $stable(dav_q)));
endmodule

// File: rtl/pdc_acq_unit.sv
module pdc_acq_unit
   import pdc_acq_pkg::*;
#(
   parameter int CNT_W      = 6,
   parameter bit CORRECT_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pkt_sof,
   input  logic       byte_vld,
   input  logic [7:0] byte_data,
   input  logic       row_sel,
   input  logic       fmt2_sel,
   input  logic       dew_start,
   input  logic       host_busy,
   input  logic       rd_fmt2,
   input  logic [2:0] rd_idx,
   output logic [7:0] rd_data,
   output logic       dav_n
);
   generate
      if ((1 << CNT_W) <= F2_HI + 1) begin : g_bad_cnt
         $error("CNT_W too narrow for packet index");
      end
      if (2 * OUT_N - 1 != NIB_N) begin : g_bad_map
         $error("nibble count does not fill the image");
      end
   endgenerate

   logic                commit, commit_fmt2, commit_bad;
   logic [NIB_N*4-1:0]  nib_flat;
   logic [OUT_N*8-1:0]  f1_flat;

   pdc_pkt_capture #(.CNT_W(CNT_W), .CORRECT_EN(CORRECT_EN)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .pkt_sof     (pkt_sof),
      .byte_vld    (byte_vld),
      .byte_data   (byte_data),
      .row_sel     (row_sel),
      .fmt2_sel    (fmt2_sel),
      .commit      (commit),
      .commit_fmt2 (commit_fmt2),
      .commit_bad  (commit_bad),
      .nib_flat    (nib_flat),
      .f1_flat     (f1_flat)
   );

   pdc_xfer_image u_img (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (commit),
      .commit_fmt2 (commit_fmt2),
      .commit_bad  (commit_bad),
      .nib_flat    (nib_flat),
      .f1_flat     (f1_flat),
      .dew_start   (dew_start),
      .host_busy   (host_busy),
      .rd_fmt2     (rd_fmt2),
      .rd_idx      (rd_idx),
      .rd_data     (rd_data),
      .dav_n       (dav_n)
   );
endmodule

// File: tb/pdc_acq_unit_tb_top.sv
`timescale 1ns/1ps
module pdc_acq_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pkt_sof = 1'b0, byte_vld = 1'b0, row_sel = 1'b0, fmt2_sel = 1'b0;
   logic       dew_start = 1'b0, host_busy = 1'b0, rd_fmt2 = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic [2:0] rd_idx = 3'd0;
   logic [7:0] rd_data;
   logic       dav_n;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   logic [7:0] pkt  [1:26];
   logic [3:0] nibs [13:25];
   logic [7:0] exp2 [0:6];
   logic [7:0] exp1 [0:6];
   logic       exp_dav;

   always #4 clk = ~clk;

   pdc_acq_unit dut_i (
      .clk(clk), .rst_n(rst_n), .pkt_sof(pkt_sof), .byte_vld(byte_vld),
      .byte_data(byte_data), .row_sel(row_sel), .fmt2_sel(fmt2_sel),
      .dew_start(dew_start), .host_busy(host_busy), .rd_fmt2(rd_fmt2),
      .rd_idx(rd_idx), .rd_data(rd_data), .dav_n(dav_n)
   );

   function automatic logic [7:0] enc(input logic [3:0] n);
      logic [7:0] c;
      c[1] = n[0]; c[3] = n[1]; c[5] = n[2]; c[7] = n[3];
      c[0] = n[0] ^ n[2] ^ n[3];
      c[2] = n[0] ^ n[1] ^ n[3];
      c[4] = n[0] ^ n[1] ^ n[2];
      c[6] = c[0] ^ c[1] ^ c[2] ^ c[3] ^ c[4] ^ c[5] ^ c[7];
      return c;
   endfunction

   function automatic logic [3:0] r4(input logic [3:0] n);
      return {n[0], n[1], n[2], n[3]};
   endfunction

   function automatic logic [7:0] r8(input logic [7:0] b);
      return {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string tag);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   task automatic check_all(input string tag);
      chk({7'd0, dav_n}, {7'd0, exp_dav}, {tag, " dav_n"});
      for (int f = 0; f < 2; f++) begin
         for (int k = 0; k < 8; k++) begin
            rd_fmt2 = f[0];
            rd_idx  = k[2:0];
            #1;
            if (k == 7)      chk(rd_data, 8'hFF, {tag, " R9 idx7"});
            else if (f == 1) chk(rd_data, exp2[k], {tag, " fmt2 img"});
            else             chk(rd_data, exp1[k], {tag, " fmt1 img"});
         end
      end
   endtask

   // fill pkt: nibbles random, err 0 none / 1 single / 2 double per label byte
   task automatic build(input bit f2, input int single_pct, input int dbl_one);
      for (int i = 1; i <= 26; i++) pkt[i] = 8'($urandom);
      if (f2) begin
         for (int i = 13; i <= 25; i++) begin
            nibs[i] = 4'($urandom);
            pkt[i]  = enc(nibs[i]);
            if (i == dbl_one) begin
               int a = $urandom % 8;
               int b = (a + 1 + ($urandom % 7)) % 8;
               pkt[i][a] = ~pkt[i][a];
               pkt[i][b] = ~pkt[i][b];
            end else if (int'($urandom % 100) < single_pct) begin
               int a = $urandom % 8;
               pkt[i][a] = ~pkt[i][a];
            end
         end
      end
   endtask

   task automatic send(input bit row, input bit f2, input bit busy, input bit bad, input bit tchk);
      logic old_dav = exp_dav;
      for (int i = 1; i <= 26; i++) begin
         byte_vld = 1'b1; pkt_sof = (i == 1); byte_data = pkt[i];
         row_sel = row; fmt2_sel = f2; host_busy = busy;
         @(negedge clk);
         // after the edge accepting byte 25 only the commit register has moved
         if (tchk && i == 25) chk({7'd0, dav_n}, {7'd0, old_dav}, "R6 not early");
      end
      byte_vld = 1'b0; pkt_sof = 1'b0; row_sel = 1'b0;
      repeat (2) @(negedge clk);
      host_busy = 1'b0;
      if (row && !busy) begin
         if (f2 && !bad) begin
            exp2[0] = {r4(nibs[16]), r4(nibs[17])};
            exp2[1] = {r4(nibs[18]), r4(nibs[19])};
            exp2[2] = {r4(nibs[20]), r4(nibs[21])};
            exp2[3] = {r4(nibs[22]), r4(nibs[23])};
            exp2[4] = {r4(nibs[14]), r4(nibs[15])};
            exp2[5] = {r4(nibs[24]), r4(nibs[25])};
            exp2[6] = {r4(nibs[13]), 4'hF};
            exp_dav = 1'b0;
         end else if (!f2) begin
            for (int k = 0; k < 7; k++) exp1[k] = r8(pkt[15 + k]);
         end
      end
   endtask

   task automatic dew();
      dew_start = 1'b1;
      @(negedge clk);
      dew_start = 1'b0;
      exp_dav = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C1D));
      for (int k = 0; k < 7; k++) begin exp2[k] = 8'hFF; exp1[k] = 8'hFF; end
      exp_dav = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R10 reset");

      build(1, 0, 0);  send(1, 1, 0, 0, 1);  check_all("R4 R5 R6 clean fmt2");
      dew();           check_all("R7 dew");
      build(0, 0, 0);  send(1, 0, 0, 0, 0);  check_all("R3 R6 fmt1");
      build(1, 100, 0); send(1, 1, 0, 0, 1); check_all("R2 single fix");
      dew();
      build(1, 0, 19); send(1, 1, 0, 1, 0);  check_all("R2 double drop");
      build(1, 0, 0);  send(0, 1, 0, 0, 0);  check_all("R1 wrong row");
      build(0, 0, 0);  send(0, 0, 0, 0, 0);  check_all("R1 wrong row fmt1");
      build(1, 0, 0);  send(1, 1, 1, 0, 0);  check_all("R8 busy fmt2");
      build(0, 0, 0);  send(1, 0, 1, 0, 0);  check_all("R8 busy fmt1");
      build(1, 0, 0);  send(1, 1, 0, 0, 1);
      dew_start = 1'b1; @(negedge clk); dew_start = 1'b0; exp_dav = 1'b1;
      check_all("R7 dew after store");

      for (int n = 0; n < 160; n++) begin
         bit row  = ($urandom % 5) != 0;
         bit f2   = $urandom % 2;
         bit busy = ($urandom % 6) == 0;
         int dbl  = (($urandom % 8) == 0) ? 13 + int'($urandom % 13) : 0;
         build(f2, 10, dbl);
         send(row, f2, busy, dbl != 0, 0);
         if (($urandom % 3) == 0) dew();
         check_all("RND R1 R2 R3 R4 R8");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule